// File: doc/BRIEF.md
# SRAM Read Output Pipeline with Deselect Timing

This block is the read-data output stage of a synchronous SRAM. Each clock cycle carries one command: read, deselect or no-op. The block tracks each command through a short delay line. It decides in which cycle a read word appears on the data outputs and in which cycle the output drivers turn off. The array supplies its word on `arr_rdata` in the cycle after a read command is sampled.

Two static mode inputs choose the timing:

- `bypass_sel` picks either a combinational flow-through path or a path through a rising-edge output register.
- `dual_desel` picks whether a deselect turns the drivers off one or two cycles after it is sampled.

With both inputs low, the block runs in the default mode: registered output and single-cycle deselect.

An active-low output enable gates the drivers without waiting for a clock edge, and so does a write-in-progress flag. While the drivers are off, the data bus is held at zero. `dq_oe` is the tri-state control for the pads.

Top module: `rdo_out_pipe`

## Requirements
- R1: While `rst_n` is low (asynchronous), `rd_valid`, `dq_oe` and `dq_out` are all zero. The remembered drive state is cleared, so drivers stay off after release until a new read beat arrives.
- R2: With `bypass_sel`=1 (flow-through), a read command (`cmd_i`=2'b01) sampled at edge n sets `rd_valid` for the cycle between edge n and n+1. In that cycle `dq_out` equals the `arr_rdata` value present in that same cycle.
- R3: With `bypass_sel`=0 (registered), a read sampled at edge n sets `rd_valid` for the cycle between edge n+1 and n+2. In that cycle `dq_out` equals the `arr_rdata` value that was present between edge n and n+1.
- R4: Reads issued on consecutive cycles produce one beat per cycle, in issue order, in both output modes.
- R5: With `dual_desel`=0, a deselect (`cmd_i`=2'b10) sampled at edge n turns `dq_oe` off from edge n onward. The exception is a fresh read beat shown in that cycle: it is still driven for that one cycle, and the drivers go off after it.
- R6: With `dual_desel`=1, a deselect sampled at edge n leaves the last word driven until edge n+1 and turns `dq_oe` off from edge n+1 onward.
- R7: After a beat, no-op cycles (`cmd_i`=2'b00 or 2'b11) keep driving the last word with `rd_valid` low, until a deselect takes effect.
- R8: `oe_n` high forces `dq_oe` low at once, with no clock edge needed. Returning `oe_n` low restores the drive.
- R9: `wr_act` high forces `dq_oe` low. The remembered drive state and the held word are unchanged, so drive resumes when `wr_act` falls.
- R10: `dq_out` is all zeros whenever `dq_oe` is low.
- R11: This case applies with `bypass_sel`=1 and `dual_desel`=1. Suppose an earlier deselect reaches turn-off in the same cycle as the beat of a later read. The beat is shown, and its word is then held and driven on the following no-op cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_sel | input | 1 | Static: 1 flow-through, 0 registered output |
| dual_desel | input | 1 | Static: 1 two-cycle deselect, 0 one-cycle |
| cmd_i | input | 2 | Command: 00/11 no-op, 01 read, 10 deselect |
| arr_rdata | input | DATA_W | Word from the array, valid the cycle after a read is sampled |
| oe_n | input | 1 | Asynchronous active-low output enable |
| wr_act | input | 1 | Write in progress, blocks driving |
| rd_valid | output | 1 | A fresh read beat is on `dq_out` this cycle |
| dq_oe | output | 1 | Output driver enable (tri-state control) |
| dq_out | output | DATA_W | Output word, zero when not driven |

## Verification
Some properties are checked on every clock:

- the read latency in each output mode, against a delayed copy of the command stream;
- the gating of the drivers by the output enable and the write flag;
- the zero bus whenever the drivers are off;
- the turn-off cycle after a deselect in each deselect mode, whenever no fresh beat competes with it.

Other behaviour can only be shown by the bench scenarios:

- which array word appears in which cycle;
- the holding of the last word across no-op cycles;
- the way a fresh beat and a deselect resolve when they meet;
- the asynchronous response to the output enable between clock edges.

The bench runs the four combinations of output mode and deselect mode, including read, deselect, read sequences.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

   // Per-cycle command on cmd_i
   typedef enum logic [1:0] {
      CMD_NOP     = 2'b00,
      CMD_READ    = 2'b01,
      CMD_DESEL   = 2'b10,
      CMD_NOP_ALT = 2'b11
   } rdo_cmd_e;

   // Stage (1-based) at which each event acts on the outputs
   localparam int unsigned STG_BEAT_FLOW = 1;
   localparam int unsigned STG_BEAT_REG  = 2;
   localparam int unsigned STG_OFF_ONE   = 1;
   localparam int unsigned STG_OFF_TWO   = 2;

   // Delay line depth: deepest stage any event uses
   localparam int unsigned CMD_DEPTH =
      (STG_BEAT_REG > STG_OFF_TWO) ? STG_BEAT_REG : STG_OFF_TWO;

endpackage

// File: rtl/rdo_cmd_pipe.sv
// Captures the command in the input register and walks read / deselect
// flags down a delay line, one stage per clock.
module rdo_cmd_pipe
   import rdo_pkg::*;
#(
   parameter int unsigned DEPTH = CMD_DEPTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cmd_i,
   output logic [DEPTH-1:0] rd_stg,
   output logic [DEPTH-1:0] ds_stg
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rdo_cmd_pipe: DEPTH must be at least 2");
      end
   endgenerate

   rdo_cmd_e cmd;
   logic     rd_in;
   logic     ds_in;

   assign cmd   = rdo_cmd_e'(cmd_i);
   assign rd_in = (cmd == CMD_READ);
   assign ds_in = (cmd == CMD_DESEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_stg <= '0;
         ds_stg <= '0;
      end else begin
         rd_stg <= {rd_stg[DEPTH-2:0], rd_in};
         ds_stg <= {ds_stg[DEPTH-2:0], ds_in};
      end
   end

endmodule

// File: rtl/rdo_data_path.sv
// Holds the last word read from the array and selects flow-through or
// registered presentation.
module rdo_data_path #(
   parameter int unsigned DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bypass_sel,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [DATA_W-1:0] word_o
);

   logic [DATA_W-1:0] word_q;

   // Rising-edge output register: loads the array word the cycle it is valid
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (cap_en) begin
         word_q <= arr_rdata;
      end
   end

   // Flow-through shows the array word in its own cycle, then the held copy
   assign word_o = (bypass_sel && cap_en) ? arr_rdata : word_q;

endmodule

// File: rtl/rdo_drive_ctl.sv
// Decides when a fresh beat is present and whether the drivers stay on.
module rdo_drive_ctl
   import rdo_pkg::*;
#(
   parameter int unsigned DEPTH = CMD_DEPTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bypass_sel,
   input  logic             dual_desel,
   input  logic [DEPTH-1:0] rd_stg,
   input  logic [DEPTH-1:0] ds_stg,
   output logic             beat_o,
   output logic             drive_o
);

   localparam int unsigned IDX_BEAT_FLOW = STG_BEAT_FLOW - 1;
   localparam int unsigned IDX_BEAT_REG  = STG_BEAT_REG - 1;
   localparam int unsigned IDX_OFF_ONE   = STG_OFF_ONE - 1;
   localparam int unsigned IDX_OFF_TWO   = STG_OFF_TWO - 1;

   generate
      if (DEPTH < STG_BEAT_REG || DEPTH < STG_OFF_TWO) begin : g_bad_depth
         $error("rdo_drive_ctl: DEPTH shallower than an event stage");
      end
   endgenerate

   logic off;
   logic off_older;
   logic hold_q;

   always_comb begin
      beat_o = bypass_sel ? rd_stg[IDX_BEAT_FLOW] : rd_stg[IDX_BEAT_REG];
      off    = dual_desel ? ds_stg[IDX_OFF_TWO] : ds_stg[IDX_OFF_ONE];
      // A turn-off stage deeper than the beat stage belongs to an older command
      off_older = (dual_desel ? STG_OFF_TWO : STG_OFF_ONE) >
                  (bypass_sel ? STG_BEAT_FLOW : STG_BEAT_REG);
      drive_o = beat_o | (hold_q & ~off);
   end

   // Keep driving after a beat until a deselect younger than it takes effect
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
      end else begin
         hold_q <= drive_o & ~(off & ~(beat_o & off_older));
      end
   end

endmodule

// File: rtl/rdo_out_pipe.sv
module rdo_out_pipe
   import rdo_pkg::*;
#(
   parameter int unsigned DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bypass_sel,
   input  logic              dual_desel,
   input  logic [1:0]        cmd_i,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic              oe_n,
   input  logic              wr_act,
   output logic              rd_valid,
   output logic              dq_oe,
   output logic [DATA_W-1:0] dq_out
);

   localparam int unsigned DEPTH = CMD_DEPTH;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("rdo_out_pipe: DATA_W must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0]  rd_stg;
   logic [DEPTH-1:0]  ds_stg;
   logic              beat;
   logic              drive;
   logic [DATA_W-1:0] word;

   rdo_cmd_pipe #(.DEPTH(DEPTH)) i_cmd (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd_i  (cmd_i),
      .rd_stg (rd_stg),
      .ds_stg (ds_stg)
   );

   rdo_data_path #(.DATA_W(DATA_W)) i_data (
      .clk        (clk),
      .rst_n      (rst_n),
      .bypass_sel (bypass_sel),
      .cap_en     (rd_stg[0]),
      .arr_rdata  (arr_rdata),
      .word_o     (word)
   );

   rdo_drive_ctl #(.DEPTH(DEPTH)) i_drv (
      .clk        (clk),
      .rst_n      (rst_n),
      .bypass_sel (bypass_sel),
      .dual_desel (dual_desel),
      .rd_stg     (rd_stg),
      .ds_stg     (ds_stg),
      .beat_o     (beat),
      .drive_o    (drive)
   );

   // Asynchronous gating by output enable and write activity
   assign rd_valid = beat;
   assign dq_oe    = ~oe_n & drive & ~wr_act;
   assign dq_out   = dq_oe ? word : '0;

endmodule

// File: rtl/rdo_out_pipe_chk.sv
module rdo_out_pipe_chk #(
   parameter int unsigned DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bypass_sel,
   input logic              dual_desel,
   input logic [1:0]        cmd_i,
   input logic              oe_n,
   input logic              wr_act,
   input logic              rd_valid,
   input logic              dq_oe,
   input logic [DATA_W-1:0] dq_out
);

   // Independent record of the command stream seen at the ports
   logic rd_d1, rd_d2, ds_d1, ds_d2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_d1 <= 1'b0;
         rd_d2 <= 1'b0;
         ds_d1 <= 1'b0;
         ds_d2 <= 1'b0;
      end else begin
         rd_d1 <= (cmd_i == 2'b01);
         rd_d2 <= rd_d1;
         ds_d1 <= (cmd_i == 2'b10);
         ds_d2 <= ds_d1;
      end
   end

   assert_flow_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_sel |-> (rd_valid == rd_d1));

   assert_reg_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bypass_sel |-> (rd_valid == rd_d2));

   assert_single_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!dual_desel && ds_d1 && !rd_valid) |-> !dq_oe);

   assert_dual_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dual_desel && ds_d2 && !rd_valid) |-> !dq_oe);

   assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_oe);

   assert_write_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_act |-> !dq_oe);

   assert_zero_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> (dq_out == '0));

endmodule

bind rdo_out_pipe rdo_out_pipe_chk #(.DATA_W(DATA_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bypass_sel (bypass_sel),
   .dual_desel (dual_desel),
   .cmd_i      (cmd_i),
   .oe_n       (oe_n),
   .wr_act     (wr_act),
   .rd_valid   (rd_valid),
   .dq_oe      (dq_oe),
   .dq_out     (dq_out)
);

// File: tb/test_rdo_out_pipe.sv
`timescale 1ns/100ps
module test_rdo_out_pipe;

   localparam int DW  = 36;
   localparam int NV  = 43;
   localparam int C_N = 0;
   localparam int C_R = 1;
   localparam int C_D = 2;

   typedef struct packed {
      logic       rst;
      logic       byp;
      logic       dual;
      logic [1:0] cmd;
      logic       oen;
      logic       wr;
      logic       ev;
      logic       eo;
      logic [7:0] tag;
      logic [3:0] req;
   } row_t;

   function automatic row_t mk(int rs, int b, int d, int c, int o, int w,
                               int v, int e, int t, int q);
      row_t r;
      r.rst  = 1'(rs);
      r.byp  = 1'(b);
      r.dual = 1'(d);
      r.cmd  = 2'(c);
      r.oen  = 1'(o);
      r.wr   = 1'(w);
      r.ev   = 1'(v);
      r.eo   = 1'(e);
      r.tag  = 8'(t);
      r.req  = 4'(q);
      return r;
   endfunction

   // rst byp dual cmd oe_n wr | exp_valid exp_oe data_tag req
   localparam row_t VEC [NV] = '{
      // registered output, one-cycle deselect
      mk(1,0,0,C_N,0,0, 0,0, 0, 1),
      mk(0,0,0,C_R,0,0, 0,0, 0, 3),
      mk(0,0,0,C_N,0,0, 0,0, 0, 3),
      mk(0,0,0,C_D,0,0, 1,1, 2, 3),
      mk(0,0,0,C_R,0,0, 0,0, 0, 5),
      mk(0,0,0,C_N,0,0, 0,0, 0, 5),
      mk(0,0,0,C_R,0,0, 1,1, 5, 3),
      mk(0,0,0,C_D,0,0, 0,1, 5, 7),
      mk(0,0,0,C_N,0,0, 1,1, 7, 5),
      mk(0,0,0,C_N,0,0, 0,0, 0, 5),
      // registered output, two-cycle deselect
      mk(1,0,1,C_N,0,0, 0,0, 0, 1),
      mk(0,0,1,C_R,0,0, 0,0, 0, 3),
      mk(0,0,1,C_R,0,0, 0,0, 0, 4),
      mk(0,0,1,C_D,0,0, 1,1,12, 4),
      mk(0,0,1,C_N,0,0, 1,1,13, 4),
      mk(0,0,1,C_N,0,0, 0,0, 0, 6),
      mk(0,0,1,C_R,0,0, 0,0, 0, 6),
      mk(0,0,1,C_N,0,0, 0,0, 0, 6),
      mk(0,0,1,C_D,0,0, 1,1,17, 3),
      mk(0,0,1,C_R,0,0, 0,1,17, 6),
      mk(0,0,1,C_N,0,0, 0,0, 0, 6),
      mk(0,0,1,C_N,0,0, 1,1,20, 3),
      mk(0,0,1,C_N,0,0, 0,1,20, 7),
      mk(0,0,1,C_N,1,0, 0,0, 0, 8),
      mk(0,0,1,C_N,0,1, 0,0, 0, 9),
      mk(0,0,1,C_N,0,0, 0,1,20, 9),
      // flow-through, one-cycle deselect
      mk(1,1,0,C_N,0,0, 0,0, 0, 1),
      mk(0,1,0,C_R,0,0, 0,0, 0, 2),
      mk(0,1,0,C_R,0,0, 1,1,28, 2),
      mk(0,1,0,C_D,0,0, 1,1,29, 4),
      mk(0,1,0,C_R,0,0, 0,0, 0, 5),
      mk(0,1,0,C_N,0,0, 1,1,31, 2),
      mk(0,1,0,C_N,0,0, 0,1,31, 7),
      mk(0,1,0,C_D,0,0, 0,1,31, 7),
      mk(0,1,0,C_N,0,0, 0,0, 0, 5),
      // flow-through, two-cycle deselect
      mk(1,1,1,C_N,0,0, 0,0, 0, 1),
      mk(0,1,1,C_R,0,0, 0,0, 0, 2),
      mk(0,1,1,C_D,0,0, 1,1,37, 2),
      mk(0,1,1,C_R,0,0, 0,1,37, 6),
      mk(0,1,1,C_N,0,0, 1,1,39,11),
      mk(0,1,1,C_D,0,0, 0,1,39,11),
      mk(0,1,1,C_N,0,0, 0,1,39,11),
      mk(0,1,1,C_N,0,0, 0,0, 0, 6)
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          bypass_sel;
   logic          dual_desel;
   logic [1:0]    cmd_i;
   logic [DW-1:0] arr_rdata;
   logic          oe_n;
   logic          wr_act;
   logic          rd_valid;
   logic          dq_oe;
   logic [DW-1:0] dq_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rdo_out_pipe #(.DATA_W(DW)) i_rdo_out_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .bypass_sel (bypass_sel),
      .dual_desel (dual_desel),
      .cmd_i      (cmd_i),
      .arr_rdata  (arr_rdata),
      .oe_n       (oe_n),
      .wr_act     (wr_act),
      .rd_valid   (rd_valid),
      .dq_oe      (dq_oe),
      .dq_out     (dq_out)
   );

   function automatic logic [DW-1:0] word_of(int t);
      return 36'h9_0000_0000 | DW'(t & 255);
   endfunction

   function automatic string rname(int n);
      case (n)
         1:  return "R1";
         2:  return "R2";
         3:  return "R3";
         4:  return "R4";
         5:  return "R5";
         6:  return "R6";
         7:  return "R7";
         8:  return "R8";
         9:  return "R9";
         10: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(string req, string what, logic [DW-1:0] act,
                      logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s at %0t: actual %h expected %h",
                  req, what, $time, act, exp);
      end
   endtask

   initial begin
      rst_n      = 1'b0;
      bypass_sel = 1'b0;
      dual_desel = 1'b0;
      cmd_i      = 2'(C_N);
      arr_rdata  = '0;
      oe_n       = 1'b0;
      wr_act     = 1'b0;

      // Vector table: inputs driven after the falling edge, outputs sampled
      // 1 ns later, before the next rising edge.
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         rst_n      = !VEC[i].rst;
         bypass_sel = VEC[i].byp;
         dual_desel = VEC[i].dual;
         cmd_i      = VEC[i].cmd;
         oe_n       = VEC[i].oen;
         wr_act     = VEC[i].wr;
         arr_rdata  = word_of(i);
         #1;
         chk(rname(int'(VEC[i].req)), "rd_valid", DW'(rd_valid), DW'(VEC[i].ev));
         chk(rname(int'(VEC[i].req)), "dq_oe", DW'(dq_oe), DW'(VEC[i].eo));
         if (VEC[i].eo)
            chk(rname(int'(VEC[i].req)), "dq_out", dq_out, word_of(int'(VEC[i].tag)));
         else
            chk("R10", "dq_out", dq_out, '0);
      end

      // Directed: output enable acts between clock edges (R8)
      @(negedge clk);
      rst_n = 1'b0; bypass_sel = 1'b0; dual_desel = 1'b0; cmd_i = 2'(C_N);
      @(negedge clk);
      rst_n = 1'b1; cmd_i = 2'(C_R); arr_rdata = word_of(100);
      @(negedge clk);
      cmd_i = 2'(C_N); arr_rdata = word_of(101);
      @(negedge clk);
      arr_rdata = word_of(102);
      #0.5;
      chk("R3", "dq_out registered beat", dq_out, word_of(101));
      oe_n = 1'b1;
      #0.2;
      chk("R8", "dq_oe with oe_n high", DW'(dq_oe), DW'(0));
      chk("R10", "dq_out with oe_n high", dq_out, '0);
      oe_n = 1'b0;
      #0.2;
      chk("R8", "dq_oe restored", DW'(dq_oe), DW'(1));

      // Directed: reset while driving (R1)
      @(negedge clk);
      #0.5;
      chk("R7", "dq_oe held before reset", DW'(dq_oe), DW'(1));
      rst_n = 1'b0;
      #0.2;
      chk("R1", "rd_valid in reset", DW'(rd_valid), DW'(0));
      chk("R1", "dq_oe in reset", DW'(dq_oe), DW'(0));
      chk("R1", "dq_out in reset", dq_out, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R1", "dq_oe after release", DW'(dq_oe), DW'(0));

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule